// File: doc/BRIEF.md
# Three-Area Address Translator

This block sits between an 8-bit processor's 16-bit address bus and a 1 MB physical memory. Each logical address is split into sixteen 4 KB pages by its top four bits. Two programmable page boundaries cut the logical space into a low, a middle and a high area. The low area is passed through unchanged. The middle and high areas each add their own programmable base, shifted up by 12 bits, to produce a 20-bit physical address. The sum wraps inside the 1 MB space.

Software sets the two boundaries and the two bases through a small byte-wide register port. The translation path has no register in it, so the physical address follows the logical address in the same cycle. After reset every logical address maps to the identical physical address, so code written for a plain 64 KB machine runs without setup. A typical layout leaves 0000h–3FFFh in place, moves 4000h–7FFFh to 10000h and moves 8000h–FFFFh to 40000h.

Top module: `mmu3Area`

## Requirements
- R1: The physical address is always 20 bits, and its low 12 bits equal logAddr[11:0].
- R2: With page = logAddr[15:12], an address is in the high area when page >= upper boundary. Otherwise it is in the middle area when page >= lower boundary. Otherwise it is in the low area. The high-area test takes priority even when upper < lower.
- R3: The low area adds zero. The middle area adds base1 << 12. The high area adds base2 << 12.
- R4: The addition is taken modulo 2^20, so a sum past FFFFFh wraps to the bottom of the space.
- R5: After reset the boundary register reads FFh (lower = upper = Fh), both bases read 00h, and physAddr equals logAddr zero-extended.
- R6: Register index 0 holds the boundaries, with upper in bits [7:4] and lower in bits [3:0]. Index 1 is base1 and index 2 is base2. A write takes effect on the clock edge where regWrEn is high. Reads are combinational on regRdData.
- R7: Register index 3 always reads 00h, and writes to it change neither any register nor the translation.
- R8: physAddr depends combinationally on logAddr, with no cycle of delay. A register write changes the translation from the cycle after the write edge.
- R9: The layout lower = 4, upper = 8, base1 = 0Ch, base2 = 38h maps 0000h–3FFFh to itself, 4000h to 10000h and 8000h to 40000h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register index for read and write |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data for regAddr |
| logAddr | input | 16 | Logical address from the processor |
| physAddr | output | 20 | Translated physical address |

## Verification
Some properties are checked on every cycle: the low 12 bits pass through, and the identity mapping holds until the first write after reset. Readback matches the data written to a base register. Register contents stay fixed in cycles without a write, and index 3 reads zero. The area choice over every boundary pair, including upper below lower, can only be shown by the bench's sweeps. So can the per-area offset, the wrap past 1 MB, and the example three-window layout, because those need expected sums computed from a known register setting.

// File: rtl/mmu3AreaPkg.sv
package mmu3AreaPkg;
  localparam int DATA_W = 8;

  typedef struct packed {
    logic              wrBound;
    logic              wrBase1;
    logic              wrBase2;
    logic [DATA_W-1:0] data;
  } regStrobeT;

  typedef enum logic [1:0] {
    AREA_LOW  = 2'd0,
    AREA_MID  = 2'd1,
    AREA_HIGH = 2'd2
  } areaT;
endpackage

// File: rtl/mmu3AreaCtrl.sv
module mmu3AreaCtrl
  import mmu3AreaPkg::*;
(
  input  logic              regWrEn,
  input  logic [1:0]        regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output regStrobeT         strobe
);
  always_comb begin
    strobe         = '0;
    strobe.data    = regWrData;
    if (regWrEn) begin
      unique case (regAddr)
        2'd0:    strobe.wrBound = 1'b1;
        2'd1:    strobe.wrBase1 = 1'b1;
        2'd2:    strobe.wrBase2 = 1'b1;
        default: ; // index 3 has no storage
      endcase
    end
  end
endmodule

// File: rtl/mmu3AreaDatapath.sv
module mmu3AreaDatapath
  import mmu3AreaPkg::*;
#(
  parameter int LOG_W  = 16,
  parameter int PHYS_W = 20,
  parameter int PAGE_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobeT         strobe,
  input  logic [1:0]        regAddr,
  output logic [DATA_W-1:0] regRdData,
  input  logic [LOG_W-1:0]  logAddr,
  output logic [PHYS_W-1:0] physAddr
);
  localparam int OFS_SHIFT = LOG_W - PAGE_W;
  localparam int EXT_W     = PHYS_W - LOG_W;
  localparam logic [PAGE_W-1:0] PAGE_TOP = '1;

  logic [PAGE_W-1:0] lowerBound, upperBound;
  logic [DATA_W-1:0] base1Reg, base2Reg;
  logic [PAGE_W-1:0] page;
  areaT              area;
  logic [DATA_W-1:0] baseSel;
  logic [PHYS_W-1:0] offset;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowerBound <= PAGE_TOP;
      upperBound <= PAGE_TOP;
      base1Reg   <= '0;
      base2Reg   <= '0;
    end else begin
      if (strobe.wrBound) begin
        lowerBound <= strobe.data[PAGE_W-1:0];
        upperBound <= strobe.data[2*PAGE_W-1:PAGE_W];
      end
      if (strobe.wrBase1) base1Reg <= strobe.data;
      if (strobe.wrBase2) base2Reg <= strobe.data;
    end
  end

  always_comb begin
    unique case (regAddr)
      2'd0:    regRdData = {upperBound, lowerBound};
      2'd1:    regRdData = base1Reg;
      2'd2:    regRdData = base2Reg;
      default: regRdData = '0;
    endcase
  end

  assign page = logAddr[LOG_W-1:OFS_SHIFT];

  always_comb begin
    if (page >= upperBound)      area = AREA_HIGH;
    else if (page >= lowerBound) area = AREA_MID;
    else                         area = AREA_LOW;
  end

  always_comb begin
    unique case (area)
      AREA_MID:  baseSel = base1Reg;
      AREA_HIGH: baseSel = base2Reg;
      default:   baseSel = '0;
    endcase
  end

  assign offset   = PHYS_W'({baseSel, {OFS_SHIFT{1'b0}}});
  assign physAddr = {{EXT_W{1'b0}}, logAddr} + offset;
endmodule

// File: rtl/mmu3Area.sv
module mmu3Area
  import mmu3AreaPkg::*;
#(
  parameter int LOG_W  = 16,
  parameter int PHYS_W = 20,
  parameter int PAGE_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [1:0]        regAddr,
  input  logic [7:0]        regWrData,
  output logic [7:0]        regRdData,
  input  logic [LOG_W-1:0]  logAddr,
  output logic [PHYS_W-1:0] physAddr
);
  regStrobeT strobe;

  mmu3AreaCtrl u_ctrl (
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .strobe    (strobe)
  );

  mmu3AreaDatapath #(
    .LOG_W  (LOG_W),
    .PHYS_W (PHYS_W),
    .PAGE_W (PAGE_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .regAddr   (regAddr),
    .regRdData (regRdData),
    .logAddr   (logAddr),
    .physAddr  (physAddr)
  );
endmodule

// File: rtl/mmu3AreaChecker.sv
module mmu3AreaChecker #(
  parameter int LOG_W  = 16,
  parameter int PHYS_W = 20
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic [1:0]        regAddr,
  input logic [7:0]        regWrData,
  input logic [7:0]        regRdData,
  input logic [LOG_W-1:0]  logAddr,
  input logic [PHYS_W-1:0] physAddr
);
  logic wroteSinceReset;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        wroteSinceReset <= 1'b0;
    else if (regWrEn) wroteSinceReset <= 1'b1;
  end

  // R1: low offset bits pass straight through
  a_r1_low_bits: assert property (@(posedge clk) disable iff (!rstN)
    physAddr[11:0] == logAddr[11:0]);

  // R5: identity mapping until the first register write
  a_r5_reset_identity: assert property (@(posedge clk) disable iff (!rstN)
    !wroteSinceReset |-> physAddr == PHYS_W'(logAddr));

  // R6: a written base reads back on the next cycle
  a_r6_base_readback: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == 2'd1) |=> (regAddr != 2'd1 || regRdData == $past(regWrData)));

  // R6: contents hold without a write
  a_r6_hold: assert property (@(posedge clk) disable iff (!rstN)
    !regWrEn |=> ($stable(regAddr) -> $stable(regRdData)));

  // R7: index 3 reads zero
  a_r7_unused_zero: assert property (@(posedge clk) disable iff (!rstN)
    regAddr == 2'd3 |-> regRdData == 8'h00);
endmodule

bind mmu3Area mmu3AreaChecker #(.LOG_W(LOG_W), .PHYS_W(PHYS_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .regWrEn   (regWrEn),
  .regAddr   (regAddr),
  .regWrData (regWrData),
  .regRdData (regRdData),
  .logAddr   (logAddr),
  .physAddr  (physAddr)
);

// File: tb/mmu3Area_tb.sv
module mmu3Area_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic [7:0]  regWrData = 8'd0;
  logic [7:0]  regRdData;
  logic [15:0] logAddr = 16'd0;
  logic [19:0] physAddr;

  int vectors = 0;
  int miscompares = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  mmu3Area u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData),
    .logAddr(logAddr), .physAddr(physAddr)
  );

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [1:0] idx, input logic [7:0] val);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = idx; regWrData = val;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdCheck(input string req, input logic [1:0] idx, input int exp);
    regAddr = idx;
    #1;
    check(req, int'(regRdData), exp);
  endtask

  function automatic int model(int lo, int up, int b1, int b2, int la);
    int pg = la >> 12;
    int ofs;
    if (pg >= up)      ofs = b2 << 12;
    else if (pg >= lo) ofs = b1 << 12;
    else               ofs = 0;
    return (la + ofs) & 32'hFFFFF;
  endfunction

  task automatic xlate(input string req, input int la, input int exp);
    logAddr = 16'(la);
    #1;
    check(req, int'(physAddr), exp);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      miscompares++;
      $display("FAIL watchdog actual=%0d expected<100000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R5: reset register values and identity mapping
    rdCheck("R5 bound", 2'd0, 8'hFF);
    rdCheck("R5 base1", 2'd1, 8'h00);
    rdCheck("R5 base2", 2'd2, 8'h00);
    for (int p = 0; p < 16; p++) xlate("R5 identity", (p << 12) | (p * 273), (p << 12) | (p * 273));

    // R9: example three-window layout
    wrReg(2'd0, 8'h84); wrReg(2'd1, 8'h0C); wrReg(2'd2, 8'h38);
    xlate("R9 low end", 16'h3FFF, 20'h03FFF);
    xlate("R9 mid start", 16'h4000, 20'h10000);
    xlate("R9 mid end", 16'h7FFF, 20'h13FFF);
    xlate("R9 high start", 16'h8000, 20'h40000);
    xlate("R9 high end", 16'hFFFF, 20'h47FFF);

    // R7: index 3 reads zero and its writes change nothing
    wrReg(2'd3, 8'h5A);
    rdCheck("R7 idx3 read", 2'd3, 0);
    rdCheck("R7 bound kept", 2'd0, 8'h84);
    rdCheck("R7 base1 kept", 2'd1, 8'h0C);
    rdCheck("R7 base2 kept", 2'd2, 8'h38);
    xlate("R7 xlate kept", 16'h8123, 20'h40123);

    // R8: write takes effect after the edge, translation is same-cycle
    @(negedge clk);
    logAddr = 16'h9456;
    regWrEn = 1'b1; regAddr = 2'd2; regWrData = 8'h01;
    #1 check("R8 before edge", int'(physAddr), 20'h41456);
    @(negedge clk);
    regWrEn = 1'b0;
    #1 check("R8 after edge", int'(physAddr), 20'h0A456);
    logAddr = 16'hA456;
    #1 check("R8 comb follow", int'(physAddr), 20'h0B456);

    // R2 R3 R4 R1 R6: sweep every boundary pair over every page
    for (int lo = 0; lo < 16; lo++) begin
      for (int up = 0; up < 16; up++) begin
        int b1 = (lo * 17 + 3) & 255;
        int b2 = 240 + up;
        wrReg(2'd0, 8'((up << 4) | lo));
        wrReg(2'd1, 8'(b1));
        wrReg(2'd2, 8'(b2));
        rdCheck("R6 bound readback", 2'd0, (up << 4) | lo);
        for (int p = 0; p < 16; p++) begin
          int la = (p << 12) | ((lo * 37 + p * 91 + up) & 12'hFFF);
          xlate("R2 R3 R4 sweep", la, model(lo, up, b1, b2, la));
          check("R1 low bits", int'(physAddr[11:0]), la & 12'hFFF);
        end
      end
    end

    // R4: explicit wrap past the top of the space
    wrReg(2'd0, 8'h00); wrReg(2'd2, 8'hFF);
    xlate("R4 wrap", 16'h1234, 20'h00234);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule